// File: doc/BRIEF.md
# Dual-Mode FSK Serial Data Output

This block sits behind a caller-ID FSK demodulator and hands the demodulated bit stream to a host over three wires: a data clock, a serial data line and an active-low data-ready strobe. The analog front end is out of scope. It reaches the block as a demodulated bit with a one-cycle valid strobe, a level-present flag from the in-band amplitude detector, and a demodulator enable. Everything runs on one system clock.

A debounced carrier qualifier gates all output activity. The qualifier asserts after the level flag has been present continuously for a hold window. It releases only after the flag has been absent continuously for the same window. The window is counted in milliseconds from a divided system-clock tick. Input bits are also ignored until a settling delay has passed after the enable rises.

In device-clocked mode the block copies every qualified bit onto the data line and follows it with one clock pulse. It strobes data-ready after each well-formed byte. In host-clocked mode the block assembles each asynchronous frame into a shift register and pulls data-ready low. The host then clocks the byte out with falling edges on the clock pin, which acts as an input in this mode.

Top module: `fsk_serial_out`

## Requirements
- R1: After reset, `dclk_out`, `data_out`, `rdy_n` and `carrier_n` are all high.
- R2: `carrier_n` falls exactly HOLD_MS*CLK_PER_MS cycles after `level_ok` goes high and stays high. A presence shorter than that leaves `carrier_n` high and restarts the count.
- R3: Once low, `carrier_n` rises exactly HOLD_MS*CLK_PER_MS cycles after `level_ok` goes low and stays low. A shorter dropout leaves `carrier_n` low.
- R4: Bits are ignored while `demod_en` is low and for the first SETTLE_CYC cycles after it rises.
- R5: With `mode_host`=0 and the carrier or enable not qualified, `dclk_out`, `data_out` and `rdy_n` stay high and no clock pulse is made.
- R6: With `mode_host`=0, a qualified bit appears on `data_out` at the clock edge that samples `bit_vld`. `dclk_out` then goes low for exactly DCLK_W cycles, starting one edge later, while `data_out` holds.
- R7: A frame is a 0 start bit, 8 data bits LSB first, and a 1 stop bit, each delivered as one `bit_vld` strobe. With `mode_host`=0, a frame with a valid stop bit drives `rdy_n` low for BIT_CYC cycles from the stop-bit edge. A frame whose stop bit is 0 gives no strobe.
- R8: With `mode_host`=1, a valid frame loads its byte at the stop-bit edge. At that edge `rdy_n` goes low and `data_out` shows data bit 0. `dclk_out` stays high throughout host mode.
- R9: With `mode_host`=1 and `rdy_n` low, each falling edge on `dclk_in` advances `data_out` to the next data bit within three clock edges. `rdy_n` returns high on the 8th falling edge.
- R10: With `mode_host`=1, a byte that arrives while a previous byte is still pending replaces it. `rdy_n` stays low and the bit count restarts at data bit 0.
- R11: With `mode_host`=1 and the carrier not qualified, frames are not captured and `rdy_n` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| demod_en | input | 1 | Demodulator enable |
| level_ok | input | 1 | In-band amplitude present |
| bit_in | input | 1 | Demodulated bit |
| bit_vld | input | 1 | One-cycle strobe marking a new bit |
| mode_host | input | 1 | 0: device-clocked, 1: host-clocked |
| dclk_in | input | 1 | Host data clock (host mode) |
| dclk_out | output | 1 | Generated data clock (device mode), idle high |
| data_out | output | 1 | Serial data |
| rdy_n | output | 1 | Active-low data ready |
| carrier_n | output | 1 | Active-low qualified carrier |

## Verification
The two carrier edges fall exactly HOLD_MS*CLK_PER_MS edges after the level changes. The bench checks the edge one cycle before for the old value and the edge itself for the new one. In device mode the data bit is due at the sampling edge and the clock pulse occupies edges 1 to DCLK_W after it. Data-ready in this mode stays low for BIT_CYC edges from the stop bit. In host mode data-ready and bit 0 are due at the stop-bit edge, and each host falling edge takes three edges through the synchronizer. The bench drives and samples on falling system-clock edges and counts out those edges before each comparison.

// File: rtl/fsk_serial_out.sv
module fsk_serial_out #(
  parameter int CLK_PER_MS = 4000,
  parameter int HOLD_MS    = 8,
  parameter int SETTLE_CYC = 4000,
  parameter int DCLK_W     = 8,
  parameter int BIT_CYC    = 3333
) (
  input  logic clk,
  input  logic rst_n,
  input  logic demod_en,
  input  logic level_ok,
  input  logic bit_in,
  input  logic bit_vld,
  input  logic mode_host,
  input  logic dclk_in,
  output logic dclk_out,
  output logic data_out,
  output logic rdy_n,
  output logic carrier_n
);
  localparam int DW = $clog2(CLK_PER_MS + 1);
  localparam int HW = $clog2(HOLD_MS + 1);
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam int PW = $clog2(DCLK_W + 2);
  localparam int BW = $clog2(BIT_CYC + 1);

  // carrier qualifier
  logic [DW-1:0] div_q;
  logic [HW-1:0] ms_q;
  logic          car_n;
  wire pend = (level_ok == car_n);
  wire tick = (div_q == DW'(CLK_PER_MS - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_q <= '0; ms_q <= '0; car_n <= 1'b1;
    end else if (!pend) begin
      div_q <= '0; ms_q <= '0;
    end else if (tick) begin
      div_q <= '0;
      if (ms_q == HW'(HOLD_MS - 1)) begin
        ms_q  <= '0;
        car_n <= ~car_n;
      end else ms_q <= ms_q + 1'b1;
    end else div_q <= div_q + 1'b1;

  // enable settling
  logic [SW-1:0] set_q;
  wire en_ok = demod_en && (set_q == SW'(SETTLE_CYC));
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         set_q <= '0;
    else if (!demod_en) set_q <= '0;
    else if (!en_ok)    set_q <= set_q + 1'b1;

  wire act  = en_ok & ~car_n;
  wire take = act & bit_vld;

  // shared frame receiver
  logic [3:0] fcnt;
  logic [7:0] rx;
  wire done = take && (fcnt == 4'd9) && bit_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fcnt <= '0; rx <= '0;
    end else if (!act) fcnt <= '0;
    else if (take) begin
      if (fcnt == 4'd0) begin
        if (!bit_in) fcnt <= 4'd1;
      end else if (fcnt == 4'd9) fcnt <= 4'd0;
      else begin
        rx   <= {bit_in, rx[7:1]};
        fcnt <= fcnt + 4'd1;
      end
    end

  // device-clocked path
  logic          d0;
  logic [PW-1:0] pcnt;
  logic [BW-1:0] rcnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      d0 <= 1'b1; pcnt <= '0; rcnt <= '0;
    end else if (!act || mode_host) begin
      d0 <= 1'b1; pcnt <= '0; rcnt <= '0;
    end else begin
      if (bit_vld) begin
        d0   <= bit_in;
        pcnt <= PW'(DCLK_W + 1);
      end else if (pcnt != '0) pcnt <= pcnt - 1'b1;
      if (done) rcnt <= BW'(BIT_CYC);
      else if (rcnt != '0) rcnt <= rcnt - 1'b1;
    end

  // host-clocked path
  logic [2:0] sync_q;
  logic [7:0] sh;
  logic [2:0] bc;
  logic       rdy1;
  wire fall = sync_q[2] & ~sync_q[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= 3'b111;
    else        sync_q <= {sync_q[1:0], dclk_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh <= '1; bc <= '0; rdy1 <= 1'b1;
    end else if (!act || !mode_host) begin
      bc <= '0; rdy1 <= 1'b1;
    end else if (done) begin
      sh <= rx; bc <= '0; rdy1 <= 1'b0;
    end else if (fall && !rdy1) begin
      sh <= {1'b1, sh[7:1]};
      bc <= bc + 3'd1;
      if (bc == 3'd7) rdy1 <= 1'b1;
    end

  assign dclk_out  = mode_host | ~((pcnt != '0) && (pcnt <= PW'(DCLK_W)));
  assign data_out  = mode_host ? sh[0] : d0;
  assign rdy_n     = mode_host ? rdy1 : (rcnt == '0);
  assign carrier_n = car_n;

  // R2
  car_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(carrier_n) |-> $past(level_ok));
  // R3
  car_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(carrier_n) |-> !$past(level_ok));
  // R6
  dclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_host && $fell(dclk_out)) |-> $stable(data_out));
  // R7
  dev_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_host && $fell(rdy_n)) |-> $past(bit_vld && bit_in));
  // R8
  host_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_host && $fell(rdy_n)) |-> $past(!carrier_n));
endmodule

// File: tb/sim_fsk_serial_out.sv
module sim_fsk_serial_out;
  localparam int CLK_PERIOD = 10;
  localparam int CPM = 10, HOLD = 8, SET = 20, W = 3, BC = 12, BITP = 12;
  localparam int NWIN = CPM * HOLD;

  logic clk = 0, rst_n = 0, demod_en = 0, level_ok = 0, bit_in = 1, bit_vld = 0;
  logic mode_host = 0, dclk_in = 1;
  logic dclk_out, data_out, rdy_n, carrier_n;
  int checks = 0, fails = 0;
  bit finished = 0;

  fsk_serial_out #(.CLK_PER_MS(CPM), .HOLD_MS(HOLD), .SETTLE_CYC(SET),
                   .DCLK_W(W), .BIT_CYC(BC)) u0 (
    .clk(clk), .rst_n(rst_n), .demod_en(demod_en), .level_ok(level_ok),
    .bit_in(bit_in), .bit_vld(bit_vld), .mode_host(mode_host), .dclk_in(dclk_in),
    .dclk_out(dclk_out), .data_out(data_out), .rdy_n(rdy_n), .carrier_n(carrier_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic exp_dclk(int p, bit qual);
    return !(qual && p >= 1 && p <= W);
  endfunction
  function automatic logic exp_data(logic b, bit qual);
    return qual ? b : 1'b1;
  endfunction

  task automatic chk(string req, string what, logic a, logic e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, a, e);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b, bit qual);
    bit_in = b; bit_vld = 1; step(1); bit_vld = 0;
    for (int p = 0; p < BITP; p++) begin
      if (!mode_host) begin
        chk(qual ? "R6" : "R5", "data_out", data_out, exp_data(b, qual));
        chk(qual ? "R6" : "R5", "dclk_out", dclk_out, exp_dclk(p, qual));
      end else if (p == 0) chk("R8", "dclk_out host mode", dclk_out, 1'b1);
      if (p < BITP - 1) step(1);
    end
  endtask

  task automatic send_byte(logic [7:0] v, logic stopb, bit qual);
    send_bit(1'b0, qual);
    for (int i = 0; i < 8; i++) send_bit(v[i], qual);
    send_bit(stopb, qual);
    if (!mode_host) begin
      chk("R7", "rdy_n at stop", rdy_n, !(qual && stopb));
      step(1);
      chk("R7", "rdy_n after pulse", rdy_n, 1'b1);
    end else if (qual) begin
      chk("R8", "rdy_n loaded", rdy_n, 1'b0);
      chk("R8", "data_out bit0", data_out, v[0]);
    end else chk("R11", "rdy_n no carrier", rdy_n, 1'b1);
  endtask

  task automatic host_fall(int k, logic [7:0] v);
    dclk_in = 0; step(3);
    if (k < 8) begin
      chk("R9", "data_out shifted", data_out, v[k]);
      chk("R9", "rdy_n held", rdy_n, 1'b0);
    end else chk("R9", "rdy_n after 8th", rdy_n, 1'b1);
    dclk_in = 1; step(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] a, b;
    void'($urandom(32'd20240517));
    step(2);
    chk("R1", "dclk_out", dclk_out, 1'b1);
    chk("R1", "data_out", data_out, 1'b1);
    chk("R1", "rdy_n", rdy_n, 1'b1);
    chk("R1", "carrier_n", carrier_n, 1'b1);
    rst_n = 1; demod_en = 1; step(SET + 2);
    // R5: no carrier, device mode
    send_byte(8'hA5, 1'b1, 0);
    // R2: short presence
    level_ok = 1; step(NWIN / 2); level_ok = 0; step(2);
    chk("R2", "carrier_n after short presence", carrier_n, 1'b1);
    level_ok = 1; step(NWIN - 1);
    chk("R2", "carrier_n one cycle early", carrier_n, 1'b1);
    step(1);
    chk("R2", "carrier_n asserted", carrier_n, 1'b0);
    // R6 R7: device mode bytes
    for (int n = 0; n < 4; n++) begin
      a = 8'($urandom);
      send_byte(a, 1'b1, 1);
    end
    send_byte(8'h00, 1'b1, 1);
    send_byte(8'hFF, 1'b1, 1);
    send_byte(8'h3C, 1'b0, 1);
    // R4: enable settling
    demod_en = 0; step(2);
    send_bit(1'b0, 0);
    demod_en = 1; step(1);
    send_bit(1'b0, 0);
    step(SET);
    send_bit(1'b1, 1);
    // R8 R9: host mode
    mode_host = 1; step(2);
    chk("R8", "rdy_n idle host", rdy_n, 1'b1);
    for (int n = 0; n < 4; n++) begin
      a = (n == 0) ? 8'h01 : (n == 1) ? 8'h80 : 8'($urandom);
      send_byte(a, 1'b1, 1);
      for (int k = 1; k <= 8; k++) host_fall(k, a);
    end
    host_fall(8, 8'h00);
    // R10: replace pending byte
    a = 8'($urandom); b = ~a;
    send_byte(a, 1'b1, 1);
    host_fall(1, a); host_fall(2, a);
    send_byte(b, 1'b1, 1);
    chk("R10", "rdy_n stays low", rdy_n, 1'b0);
    chk("R10", "data_out new bit0", data_out, b[0]);
    for (int k = 1; k <= 8; k++) host_fall(k, b);
    // R3: dropout then release
    level_ok = 0; step(NWIN / 2); level_ok = 1; step(2);
    chk("R3", "carrier_n after short dropout", carrier_n, 1'b0);
    level_ok = 0; step(NWIN - 1);
    chk("R3", "carrier_n one cycle early", carrier_n, 1'b0);
    step(1);
    chk("R3", "carrier_n released", carrier_n, 1'b1);
    // R11: host mode, no carrier
    send_byte(8'h5A, 1'b1, 0);
    dclk_in = 0; step(3);
    chk("R11", "rdy_n after host clock", rdy_n, 1'b1);
    dclk_in = 1; step(3);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule